// File: doc/BRIEF.md
# DMA Command Splitter

This block accepts DMA commands from two issuers, a local compute core and a control processor, and breaks each legal command into bus units of at most 128 bytes. A unit stands for eight 16-byte beats. Every command carries an external memory address, a local store address, a byte count and a 5-bit tag. Commands wait in a 16-entry queue and run in arrival order. The block checks each command for a legal size and alignment when it leaves the queue. An illegal command raises a one-cycle error pulse and is dropped without any bus traffic.

In list mode a command points at a table of elements held in local storage. Each element gives an external address and a byte count. The elements are fetched one at a time, and their data lands in consecutive local store locations. This gathers or scatters external regions that are not contiguous. A per-tag status vector shows which tags have no work left: nothing queued, nothing being split, and no unit still waiting for an acknowledge.

Top module: `dma_splitter`

## Requirements
- R1: A size is legal when it is 1, 2, 4, 8 or 16, or any nonzero multiple of 16 up to 16384. Any other size of a direct command produces one `err_valid` pulse carrying the command's tag on `err_tag`, and the command issues no bus unit.
- R2: A legal size under 16 needs both addresses to be multiples of the size. A size of 16 or more needs both addresses to be multiples of 16. A misaligned command is rejected in the same way as in R1.
- R3: A legal command issues ceil(size/128) units in order. Unit k carries external address ext+128k and local address loc+128k. `bus_byte_en` bit i is set exactly for i < min(128, bytes remaining), and `bus_tag` is the command's tag.
- R4: The queue holds 16 commands and one more may sit in the splitting engine. While the queue is full, both ready outputs are low. Commands run in the order they were accepted.
- R5: When both issuers are valid in the same cycle, the control processor port is accepted first and `core_ready` is low in that cycle.
- R6: `tag_done[t]` is 1 exactly when no command with tag t is queued or being split and every unit with tag t has seen a `bus_ack` with `bus_ack_tag` = t.
- R7: A command with the list flag set uses the low local-address bits of its external address field as the table address, which must be 8-byte aligned. Its size is the table length in bytes and must be a nonzero multiple of 8 up to 16384. Each element is read with `lst_rd_en`/`lst_rd_addr`, and the data arrives on `lst_rd_data` one cycle later. Element bits [31:0] hold the external address and bits [46:32] the size. The elements move into consecutive local addresses that start at the command's local address. A table header that breaks these rules is rejected as in R1.
- R8: A list element whose size or alignment fails R1/R2 produces one error pulse with the command's tag. The units of earlier elements are still issued, and the remaining elements are dropped.
- R9: While `bus_req_valid` is high and `bus_req_ready` is low, the request and its addresses and byte enables hold steady into the next cycle.
- R10: After reset, both ready outputs are 1, `bus_req_valid`, `err_valid` and `lst_rd_en` are 0, and every `tag_done` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Compute core command valid |
| core_ready | output | 1 | Compute core command accepted |
| core_list | input | 1 | Compute core command is a list |
| core_ext_addr | input | 32 | Compute core external address or table address |
| core_loc_addr | input | 18 | Compute core local store address |
| core_size | input | 15 | Compute core byte count |
| core_tag | input | 5 | Compute core tag |
| ctl_valid | input | 1 | Control processor command valid |
| ctl_ready | output | 1 | Control processor command accepted |
| ctl_list | input | 1 | Control processor command is a list |
| ctl_ext_addr | input | 32 | Control processor external address or table address |
| ctl_loc_addr | input | 18 | Control processor local store address |
| ctl_size | input | 15 | Control processor byte count |
| ctl_tag | input | 5 | Control processor tag |
| bus_req_valid | output | 1 | Bus unit request |
| bus_req_ready | input | 1 | Bus takes the unit |
| bus_ext_addr | output | 32 | External address of the unit |
| bus_loc_addr | output | 18 | Local store address of the unit |
| bus_byte_en | output | 128 | Valid bytes of the unit |
| bus_tag | output | 5 | Tag of the unit |
| bus_ack | input | 1 | One unit acknowledged |
| bus_ack_tag | input | 5 | Tag of the acknowledged unit |
| lst_rd_en | output | 1 | Element table read |
| lst_rd_addr | output | 18 | Element table read address |
| lst_rd_data | input | 47 | Element read data, one cycle after the read |
| err_valid | output | 1 | Command or element rejected |
| err_tag | output | 5 | Tag of the rejected command |
| tag_done | output | 32 | Per-tag completion status |

## Verification
The hardest state to reach from the ports is a full queue with a command parked in the engine. The bench gets there by holding `bus_req_ready` low once a first command has started. It then keeps offering commands and counts how many are accepted before the ready output drops. The same stall is used for a second test: it freezes the engine while both issuers present a command in the same cycle, which shows their order. A bad element in the middle of a list cannot be reached from the command ports alone. The bench preloads its local table model with a good element followed by a bad one, and checks that exactly the first element's units appear before the error.

// File: rtl/dma_splitter.sv
module dma_splitter #(
  parameter int EXT_AW = 32,
  parameter int LS_AW  = 18,
  parameter int SZW    = 15,
  parameter int TAGW   = 5,
  parameter int QDEPTH = 16,
  parameter int CNTW   = 8,
  parameter int MAXSZ  = 16384,
  parameter int LW     = EXT_AW + SZW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  output logic              core_ready,
  input  logic              core_list,
  input  logic [EXT_AW-1:0] core_ext_addr,
  input  logic [LS_AW-1:0]  core_loc_addr,
  input  logic [SZW-1:0]    core_size,
  input  logic [TAGW-1:0]   core_tag,
  input  logic              ctl_valid,
  output logic              ctl_ready,
  input  logic              ctl_list,
  input  logic [EXT_AW-1:0] ctl_ext_addr,
  input  logic [LS_AW-1:0]  ctl_loc_addr,
  input  logic [SZW-1:0]    ctl_size,
  input  logic [TAGW-1:0]   ctl_tag,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [EXT_AW-1:0] bus_ext_addr,
  output logic [LS_AW-1:0]  bus_loc_addr,
  output logic [127:0]      bus_byte_en,
  output logic [TAGW-1:0]   bus_tag,
  input  logic              bus_ack,
  input  logic [TAGW-1:0]   bus_ack_tag,
  output logic              lst_rd_en,
  output logic [LS_AW-1:0]  lst_rd_addr,
  input  logic [LW-1:0]     lst_rd_data,
  output logic              err_valid,
  output logic [TAGW-1:0]   err_tag,
  output logic [(1<<TAGW)-1:0] tag_done
);
  localparam int QAW  = $clog2(QDEPTH);
  localparam int NTAG = 1 << TAGW;
  localparam int ENTW = 1 + TAGW + SZW + LS_AW + EXT_AW;
  localparam logic [QAW:0]   QFULL = (QAW+1)'(QDEPTH);
  localparam logic [SZW-1:0] SZMAX = SZW'(MAXSZ);

  typedef enum logic [1:0] {S_IDLE, S_LREQ, S_LDAT, S_XFER} st_t;

  function automatic logic size_ok(input logic [SZW-1:0] s);
    size_ok = (s == SZW'(1)) || (s == SZW'(2)) || (s == SZW'(4)) || (s == SZW'(8)) ||
              ((s != '0) && (s[3:0] == 4'd0) && (s <= SZMAX));
  endfunction

  function automatic logic align_ok(input logic [SZW-1:0] s, input logic [EXT_AW-1:0] e,
                                    input logic [LS_AW-1:0] l);
    if (s < SZW'(16)) align_ok = ((e[3:0] | l[3:0]) & (s[3:0] - 4'd1)) == 4'd0;
    else              align_ok = (e[3:0] == 4'd0) && (l[3:0] == 4'd0);
  endfunction

  // command queue
  logic [ENTW-1:0] q_mem [QDEPTH];
  logic [QAW-1:0]  wp, rp;
  logic [QAW:0]    qcnt;
  logic            push, pop, full;
  logic [ENTW-1:0] push_ent;
  logic [TAGW-1:0] push_tag;

  assign full       = qcnt == QFULL;
  assign ctl_ready  = !full;
  assign core_ready = !full && !ctl_valid;
  assign push       = (ctl_valid && ctl_ready) || (core_valid && core_ready);
  assign push_ent   = ctl_valid ? {ctl_list, ctl_tag, ctl_size, ctl_loc_addr, ctl_ext_addr}
                                : {core_list, core_tag, core_size, core_loc_addr, core_ext_addr};
  assign push_tag   = ctl_valid ? ctl_tag : core_tag;

  always_ff @(posedge clk) if (push) q_mem[wp] <= push_ent;

  logic              h_list;
  logic [TAGW-1:0]   h_tag;
  logic [SZW-1:0]    h_size;
  logic [LS_AW-1:0]  h_loc;
  logic [EXT_AW-1:0] h_ext;
  assign {h_list, h_tag, h_size, h_loc, h_ext} = q_mem[rp];

  // splitting engine
  st_t               st;
  logic [EXT_AW-1:0] ext_q;
  logic [LS_AW-1:0]  loc_q, lptr_q;
  logic [SZW-1:0]    rem_q, lrem_q;
  logic [TAGW-1:0]   tag_q;
  logic              lst_q;

  logic [7:0]        nb;
  logic              hs, last, head_bad, el_bad, fin;
  logic [TAGW-1:0]   fin_tag;
  logic [EXT_AW-1:0] el_ext;
  logic [SZW-1:0]    el_sz;

  assign pop      = (st == S_IDLE) && (qcnt != '0);
  assign head_bad = h_list ? !((h_size != '0) && (h_size[2:0] == 3'd0) && (h_size <= SZMAX) &&
                               (h_ext[2:0] == 3'd0))
                           : !(size_ok(h_size) && align_ok(h_size, h_ext, h_loc));
  assign el_ext   = lst_rd_data[EXT_AW-1:0];
  assign el_sz    = lst_rd_data[EXT_AW +: SZW];
  assign el_bad   = (st == S_LDAT) && !(size_ok(el_sz) && align_ok(el_sz, el_ext, loc_q));

  assign nb   = |rem_q[SZW-1:7] ? 8'd128 : {1'b0, rem_q[6:0]};
  assign hs   = bus_req_valid && bus_req_ready;
  assign last = hs && (rem_q == SZW'(nb));
  assign fin  = (pop && head_bad) || el_bad || (last && !(lst_q && lrem_q != '0));
  assign fin_tag = (st == S_IDLE) ? h_tag : tag_q;

  assign bus_req_valid = st == S_XFER;
  assign bus_ext_addr  = ext_q;
  assign bus_loc_addr  = loc_q;
  assign bus_tag       = tag_q;
  assign bus_byte_en   = {128{1'b1}} >> (8'd128 - nb);
  assign lst_rd_en     = st == S_LREQ;
  assign lst_rd_addr   = lptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; qcnt <= '0;
      st <= S_IDLE;
      ext_q <= '0; loc_q <= '0; lptr_q <= '0; rem_q <= '0; lrem_q <= '0;
      tag_q <= '0; lst_q <= 1'b0;
      err_valid <= 1'b0; err_tag <= '0;
    end else begin
      if (push) wp <= wp + QAW'(1);
      if (pop)  rp <= rp + QAW'(1);
      case ({push, pop})
        2'b10:   qcnt <= qcnt + (QAW+1)'(1);
        2'b01:   qcnt <= qcnt - (QAW+1)'(1);
        default: ;
      endcase
      err_valid <= (pop && head_bad) || el_bad;
      err_tag   <= fin_tag;
      case (st)
        S_IDLE: if (pop && !head_bad) begin
          tag_q <= h_tag;
          loc_q <= h_loc;
          lst_q <= h_list;
          if (h_list) begin
            lptr_q <= h_ext[LS_AW-1:0];
            lrem_q <= h_size;
            st     <= S_LREQ;
          end else begin
            ext_q <= h_ext;
            rem_q <= h_size;
            st    <= S_XFER;
          end
        end
        S_LREQ: st <= S_LDAT;
        S_LDAT: if (el_bad) st <= S_IDLE;
        else begin
          ext_q  <= el_ext;
          rem_q  <= el_sz;
          lptr_q <= lptr_q + LS_AW'(8);
          lrem_q <= lrem_q - SZW'(8);
          st     <= S_XFER;
        end
        S_XFER: if (hs) begin
          ext_q <= ext_q + EXT_AW'(nb);
          loc_q <= loc_q + LS_AW'(nb);
          rem_q <= rem_q - SZW'(nb);
          if (last) st <= (lst_q && lrem_q != '0) ? S_LREQ : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // per-tag outstanding work
  for (genvar t = 0; t < NTAG; t++) begin : g_tag
    logic [1:0]      inc, dec;
    logic [CNTW-1:0] cnt;
    assign inc = {1'b0, push && (push_tag == TAGW'(t))} + {1'b0, hs && (tag_q == TAGW'(t))};
    assign dec = {1'b0, bus_ack && (bus_ack_tag == TAGW'(t))} + {1'b0, fin && (fin_tag == TAGW'(t))};
    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + CNTW'(inc) - CNTW'(dec);
    end
    assign tag_done[t] = cnt == '0;
  end
endmodule

// File: rtl/dma_splitter_chk.sv
module dma_splitter_chk #(
  parameter int EXT_AW = 32,
  parameter int LS_AW  = 18
)(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_valid,
  input logic              core_ready,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [EXT_AW-1:0] bus_ext_addr,
  input logic [LS_AW-1:0]  bus_loc_addr,
  input logic [127:0]      bus_byte_en,
  input logic              lst_rd_en,
  input logic [LS_AW-1:0]  lst_rd_addr,
  input logic              err_valid
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_ext_addr) &&
    $stable(bus_loc_addr) && $stable(bus_byte_en)); // R9
  AST_BE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> bus_byte_en[0] && ((bus_byte_en & (bus_byte_en + 128'd1)) == '0)); // R3
  AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && ($countones(bus_byte_en) >= 16) |->
    (bus_ext_addr[3:0] == 4'd0) && (bus_loc_addr[3:0] == 4'd0)); // R2
  AST_CTL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> !core_ready); // R5
  AST_TABLE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    lst_rd_en |-> lst_rd_addr[2:0] == 3'd0); // R7
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> !bus_req_valid); // R1
endmodule

bind dma_splitter dma_splitter_chk #(.EXT_AW(EXT_AW), .LS_AW(LS_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .core_ready(core_ready),
  .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
  .bus_ext_addr(bus_ext_addr), .bus_loc_addr(bus_loc_addr), .bus_byte_en(bus_byte_en),
  .lst_rd_en(lst_rd_en), .lst_rd_addr(lst_rd_addr), .err_valid(err_valid)
);

// File: tb/dma_splitter_tb.sv
module dma_splitter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_valid = 0, core_list = 0, ctl_valid = 0, ctl_list = 0;
  logic [31:0] core_ext_addr = 0, ctl_ext_addr = 0;
  logic [17:0] core_loc_addr = 0, ctl_loc_addr = 0;
  logic [14:0] core_size = 0, ctl_size = 0;
  logic [4:0]  core_tag = 0, ctl_tag = 0;
  logic core_ready, ctl_ready;
  logic bus_req_valid, bus_req_ready;
  logic [31:0] bus_ext_addr;
  logic [17:0] bus_loc_addr;
  logic [127:0] bus_byte_en;
  logic [4:0] bus_tag;
  logic bus_ack;
  logic [4:0] bus_ack_tag;
  logic lst_rd_en;
  logic [17:0] lst_rd_addr;
  logic [46:0] lst_rd_data = '0;
  logic err_valid;
  logic [4:0] err_tag;
  logic [31:0] tag_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_splitter u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_valid(core_valid), .core_ready(core_ready), .core_list(core_list),
    .core_ext_addr(core_ext_addr), .core_loc_addr(core_loc_addr), .core_size(core_size), .core_tag(core_tag),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_list(ctl_list),
    .ctl_ext_addr(ctl_ext_addr), .ctl_loc_addr(ctl_loc_addr), .ctl_size(ctl_size), .ctl_tag(ctl_tag),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_ext_addr(bus_ext_addr), .bus_loc_addr(bus_loc_addr), .bus_byte_en(bus_byte_en), .bus_tag(bus_tag),
    .bus_ack(bus_ack), .bus_ack_tag(bus_ack_tag),
    .lst_rd_en(lst_rd_en), .lst_rd_addr(lst_rd_addr), .lst_rd_data(lst_rd_data),
    .err_valid(err_valid), .err_tag(err_tag), .tag_done(tag_done)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected segments, consumed by the monitor
  logic [31:0] seg_ext [1024];
  logic [17:0] seg_loc [1024];
  int          seg_sz  [1024];
  logic [4:0]  seg_tag [1024];
  int seg_wr = 0, seg_rd = 0;
  logic [31:0] m_ext; logic [17:0] m_loc; int m_rem = 0; logic [4:0] m_tag;
  int unit_cnt = 0, err_cnt = 0;
  logic [4:0] last_err_tag = 0;

  task automatic add_seg(input logic [31:0] e, input logic [17:0] l, input int s, input logic [4:0] t);
    seg_ext[seg_wr % 1024] = e; seg_loc[seg_wr % 1024] = l;
    seg_sz[seg_wr % 1024] = s;  seg_tag[seg_wr % 1024] = t;
    seg_wr++;
  endtask

  // bus and table models
  bit stall = 0, toggle = 0;
  int ack_budget = -1;
  logic [4:0] pend [1024];
  int pend_wr = 0, pend_rd = 0;
  logic [46:0] lmem [64];

  initial begin
    bus_req_ready = 0;
    forever begin
      @(posedge clk); #2;
      bus_req_ready = stall ? 1'b0 : (toggle ? ~bus_req_ready : 1'b1);
    end
  end

  initial begin
    bus_ack = 0; bus_ack_tag = 0;
    forever begin
      @(posedge clk); #2;
      if (ack_budget != 0 && pend_rd < pend_wr) begin
        bus_ack = 1; bus_ack_tag = pend[pend_rd % 1024]; pend_rd++;
        if (ack_budget > 0) ack_budget--;
      end else bus_ack = 0;
    end
  end

  always @(posedge clk) if (lst_rd_en) lst_rd_data <= lmem[lst_rd_addr[8:3]];

  // monitor
  bit hold_chk = 0;
  logic [31:0] p_ext; logic [17:0] p_loc; logic [127:0] p_be;
  initial begin
    forever begin
      @(negedge clk);
      if (hold_chk) begin
        chk(bus_req_valid, "R9", "valid held", bus_req_valid, 1);
        chk(bus_ext_addr == p_ext && bus_loc_addr == p_loc && bus_byte_en == p_be,
            "R9", "request held", bus_ext_addr, p_ext);
      end
      hold_chk = bus_req_valid && !bus_req_ready;
      p_ext = bus_ext_addr; p_loc = bus_loc_addr; p_be = bus_byte_en;
      if (err_valid) begin err_cnt++; last_err_tag = err_tag; end
      if (bus_req_valid && bus_req_ready) begin
        int nb;
        logic [127:0] ebe;
        unit_cnt++;
        pend[pend_wr % 1024] = bus_tag; pend_wr++;
        if (m_rem == 0 && seg_rd < seg_wr) begin
          m_ext = seg_ext[seg_rd % 1024]; m_loc = seg_loc[seg_rd % 1024];
          m_rem = seg_sz[seg_rd % 1024];  m_tag = seg_tag[seg_rd % 1024];
          seg_rd++;
        end
        if (m_rem == 0) chk(0, "R3", "unexpected unit", bus_ext_addr, 0);
        else begin
          nb = (m_rem > 128) ? 128 : m_rem;
          ebe = {128{1'b1}} >> (128 - nb);
          chk(bus_ext_addr == m_ext, "R3", "ext addr", bus_ext_addr, m_ext);
          chk(bus_loc_addr == m_loc, "R3", "loc addr", bus_loc_addr, m_loc);
          chk(bus_byte_en == ebe, "R3", "byte enables", bus_byte_en, ebe);
          chk(bus_tag == m_tag, "R3", "tag", bus_tag, m_tag);
          m_ext += nb; m_loc += 18'(nb); m_rem -= nb;
        end
      end
    end
  end

  function automatic bit legal(input int s, input int e, input int l);
    bit ok;
    ok = (s == 1) || (s == 2) || (s == 4) || (s == 8) || (s > 0 && s % 16 == 0 && s <= 16384);
    if (!ok) return 0;
    if (s < 16) return (e % s == 0) && (l % s == 0);
    return (e % 16 == 0) && (l % 16 == 0);
  endfunction

  task automatic send(input bit port, input bit lst, input logic [31:0] e, input logic [17:0] l,
                      input logic [14:0] s, input logic [4:0] t);
    @(negedge clk);
    if (port) begin ctl_valid = 1; ctl_list = lst; ctl_ext_addr = e; ctl_loc_addr = l; ctl_size = s; ctl_tag = t; end
    else begin core_valid = 1; core_list = lst; core_ext_addr = e; core_loc_addr = l; core_size = s; core_tag = t; end
    #1;
    while (!(port ? ctl_ready : core_ready)) begin @(negedge clk); #1; end
    @(negedge clk);
    ctl_valid = 0; core_valid = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!(&tag_done)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_one(input string req, input bit port, input int e, input int l, input int s, input logic [4:0] t);
    bit ok;
    int e0, u0, eu;
    ok = legal(s, e, l);
    e0 = err_cnt; u0 = unit_cnt;
    eu = ok ? (s + 127) / 128 : 0;
    if (ok) add_seg(32'(e), 18'(l), s, t);
    send(port, 0, 32'(e), 18'(l), 15'(s), t);
    wait_idle();
    chk(err_cnt - e0 == (ok ? 0 : 1), req, "error pulses", 128'(err_cnt - e0), 128'(ok ? 0 : 1));
    if (!ok) chk(last_err_tag == t, req, "error tag", last_err_tag, t);
    chk(unit_cnt - u0 == eu, req, "unit count", 128'(unit_cnt - u0), 128'(eu));
    chk(seg_rd == seg_wr && m_rem == 0, req, "segments consumed", 128'(seg_rd), 128'(seg_wr));
  endtask

  task automatic run_list(input string req, input int tbl, input int s, input int l, input logic [4:0] t,
                          input int exp_err, input int exp_units);
    int e0, u0;
    e0 = err_cnt; u0 = unit_cnt;
    send(1, 1, 32'(tbl), 18'(l), 15'(s), t);
    wait_idle();
    chk(err_cnt - e0 == exp_err, req, "list error pulses", 128'(err_cnt - e0), 128'(exp_err));
    if (exp_err != 0) chk(last_err_tag == t, req, "list error tag", last_err_tag, t);
    chk(unit_cnt - u0 == exp_units, req, "list unit count", 128'(unit_cnt - u0), 128'(exp_units));
    chk(seg_rd == seg_wr && m_rem == 0, req, "list segments consumed", 128'(seg_rd), 128'(seg_wr));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int acc, e0, u0;
    for (int i = 0; i < 64; i++) lmem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state
    chk(core_ready && ctl_ready, "R10", "ready after reset", {core_ready, ctl_ready}, 2'b11);
    chk(!bus_req_valid && !err_valid && !lst_rd_en, "R10", "idle outputs", {bus_req_valid, err_valid, lst_rd_en}, 0);
    chk(tag_done == '1, "R10", "tag status", tag_done, 32'hffffffff);

    // R1 size sweep, both ports
    for (int s = 0; s <= 320; s++) run_one("R1", s[0], 32'h10000, 32'h100, s, 5'(s));
    run_one("R1", 0, 32'h40000, 0, 16368, 5'd3);
    run_one("R1", 1, 32'h80000, 0, 16384, 5'd4);
    run_one("R1", 0, 32'h80000, 0, 16385, 5'd5);
    run_one("R1", 1, 32'h80000, 0, 16400, 5'd6);
    run_one("R1", 0, 32'h80000, 0, 32752, 5'd7);

    // R2 alignment sweep
    foreach (seg_sz[k]) if (k < 0) ;
    for (int si = 0; si < 6; si++) begin
      int s;
      s = (si < 4) ? (1 << si) : (si == 4 ? 16 : 48);
      for (int eo = 0; eo < 16; eo++)
        for (int lo = 0; lo < 16; lo++)
          run_one("R2", 0, 32'h3000 + eo, 32'h200 + lo, s, 5'(eo + lo));
    end

    // R9 ready toggling
    toggle = 1;
    run_one("R9", 0, 32'h20000, 32'h400, 1008, 5'd12);
    toggle = 0;

    // R5 arbitration order
    stall = 1;
    add_seg(32'h100, 18'h0, 16, 5'd1);
    send(0, 0, 32'h100, 18'h0, 15'd16, 5'd1);
    @(negedge clk);
    ctl_valid = 1; ctl_list = 0; ctl_ext_addr = 32'h200; ctl_loc_addr = 18'h10; ctl_size = 15'd32; ctl_tag = 5'd2;
    core_valid = 1; core_list = 0; core_ext_addr = 32'h300; core_loc_addr = 18'h40; core_size = 15'd16; core_tag = 5'd3;
    #1;
    chk(!core_ready, "R5", "core held off", core_ready, 0);
    chk(ctl_ready, "R5", "control accepted", ctl_ready, 1);
    add_seg(32'h200, 18'h10, 32, 5'd2);
    add_seg(32'h300, 18'h40, 16, 5'd3);
    @(negedge clk); ctl_valid = 0; #1;
    chk(core_ready, "R5", "core accepted next", core_ready, 1);
    @(negedge clk); core_valid = 0;
    stall = 0;
    wait_idle();
    chk(seg_rd == seg_wr && m_rem == 0, "R5", "order consumed", 128'(seg_rd), 128'(seg_wr));

    // R4 queue full
    stall = 1; acc = 0; u0 = unit_cnt;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      core_valid = 1; core_list = 0; core_ext_addr = 32'h1000 + 32'(16 * i);
      core_loc_addr = 18'(16 * i); core_size = 15'd16; core_tag = 5'd8;
      #1;
      if (!core_ready) break;
      add_seg(32'h1000 + 32'(16 * i), 18'(16 * i), 16, 5'd8);
      acc++;
    end
    chk(!ctl_ready, "R4", "control ready low when full", ctl_ready, 0);
    @(negedge clk); core_valid = 0;
    chk(acc == 17, "R4", "accepted before full", 128'(acc), 17);
    stall = 0;
    wait_idle();
    chk(unit_cnt - u0 == 17, "R4", "queued units", 128'(unit_cnt - u0), 17);
    chk(seg_rd == seg_wr && m_rem == 0, "R4", "arrival order", 128'(seg_rd), 128'(seg_wr));

    // R6 tag completion
    ack_budget = 0;
    add_seg(32'h7000, 18'h200, 256, 5'd7);
    send(0, 0, 32'h7000, 18'h200, 15'd256, 5'd7);
    repeat (8) @(negedge clk);
    chk(tag_done[7] == 0, "R6", "tag busy, no acks", tag_done, 32'hffffff7f);
    chk((tag_done | 32'h80) == '1, "R6", "other tags done", tag_done, 32'hffffff7f);
    ack_budget = 1;
    repeat (4) @(negedge clk);
    chk(tag_done[7] == 0, "R6", "tag busy, one ack", tag_done, 32'hffffff7f);
    ack_budget = 1;
    repeat (4) @(negedge clk);
    chk(tag_done[7] == 1, "R6", "tag done after last ack", tag_done, 32'hffffffff);
    ack_budget = -1;

    // R7 list mode
    lmem[8]  = {15'd32,  32'h2000};
    lmem[9]  = {15'd16,  32'h9010};
    lmem[10] = {15'd256, 32'h30000};
    lmem[11] = {15'd8,   32'h5008};
    add_seg(32'h2000, 18'h1000, 32, 5'd9);
    add_seg(32'h9010, 18'h1020, 16, 5'd9);
    add_seg(32'h30000, 18'h1030, 256, 5'd9);
    add_seg(32'h5008, 18'h1130, 8, 5'd9);
    run_list("R7", 32'h40, 32, 32'h1000, 5'd9, 0, 5);
    run_list("R7", 32'h40, 12, 32'h1000, 5'd13, 1, 0);
    run_list("R7", 32'h44, 8, 32'h1000, 5'd14, 1, 0);

    // R8 bad elements mid-list
    lmem[16] = {15'd64, 32'h4000};
    lmem[17] = {15'd20, 32'h4100};
    lmem[18] = {15'd16, 32'h4200};
    add_seg(32'h4000, 18'h2000, 64, 5'd10);
    run_list("R8", 32'h80, 24, 32'h2000, 5'd10, 1, 1);
    lmem[24] = {15'd32, 32'h4400};
    lmem[25] = {15'd16, 32'h4404};
    add_seg(32'h4400, 18'h3000, 32, 5'd11);
    run_list("R8", 32'hC0, 16, 32'h3000, 5'd11, 1, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule